// File: doc/BRIEF.md
# Fixed-Priority Pending Interrupt Selector

This block keeps one pending flag for each of fourteen asynchronous interrupt sources and hands the most urgent eligible one, at most one at a time, to the exception entry logic of a processor core. Sources raise their flag with a single-cycle set pulse. The external and critical external lines can also feed their flags straight from a level input. Each flag is either dropped when its interrupt is delivered or kept, depending on the kind of source and on two configuration inputs. Eligibility depends on the machine-state enable bits (external enable, critical enable, hypervisor state, problem state) and on a separate enable for the hypervisor decrementer.

A grant is registered and presented as a one-hot vector plus a 4-bit index with a valid strobe. It is held until the exception entry logic acknowledges it. The acknowledge counts as delivery, and the next grant can appear one cycle later. A summary request output stays high whenever any flag is pending.

Control is a two-state machine. `ST_IDLE` waits for an eligible request and takes the *pick* transition to `ST_WAIT` when one exists, latching the winner. Otherwise it stays in `ST_IDLE` through *idle*. `ST_WAIT` drives the grant and stays there through *hold* until acknowledge. On acknowledge it takes the *retire* transition back to `ST_IDLE` and applies the delivery clearing rules.

Top module: `ipsel_top`

## Requirements
- R1: After reset all pending flags are clear, `grant_valid_o` is 0 and `req_any_o` is 0.
- R2: A set pulse on bit i of `set_i` makes source i pending at the next clock edge. `req_any_o` is 1 whenever at least one flag is pending, including flags that are masked, and it is 0 only when every flag is clear.
- R3: Source indices, which are also the values of `grant_id_o`, run from highest to lowest priority: 0 reset, 1 machine check, 2 debug, 3 hypervisor decrementer, 4 critical external, 5 watchdog, 6 critical doorbell, 7 fixed-interval timer, 8 programmable-interval timer, 9 decrementer, 10 external, 11 doorbell, 12 performance monitor, 13 thermal. Among eligible flags the lowest index is granted. `grant_vec_o` has exactly that bit set.
- R4: Only one grant is outstanding at a time. It stays valid and unchanged until `ack_i` is high at a clock edge. After that edge `grant_valid_o` is 0 for at least one cycle. Flags that were not granted remain pending.
- R5: Sources 0, 1, 2, 5, 6, 7, 8, 11, 12 and 13 have their flag cleared by the acknowledge that delivers them.
- R6: When the level configuration bit for external (10) or critical external (4) is 1, that flag copies its line every cycle, so delivery does not clear it. When the bit is 0, the flag is set by the line being high or by a set pulse, and it is cleared on delivery.
- R7: The decrementer flag (9) is cleared on delivery only when `cfg_dec_clr_i` is 1. Otherwise it stays pending and is granted again.
- R8: The hypervisor decrementer (3) is eligible only when `hdec_en_i` is 1 and at least one of these holds: `msr_ee_i` is 1, `msr_hv_i` is 0, or `msr_pr_i` is 1. Delivery never clears its flag.
- R9: Sources 7 to 13 are eligible only when `msr_ee_i` is 1. Sources 2, 4, 5 and 6 are eligible only when `msr_ce_i` is 1. Sources 0 and 1 are never masked.
- R10: A pulse on bit i of `clr_i` withdraws flag i, except for a flag in level mode. A set pulse in the same cycle as a clear or a delivery wins, and the flag stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_i | input | 14 | Per-source set pulses |
| clr_i | input | 14 | Per-source withdraw pulses |
| ext_line_i | input | 1 | External interrupt line |
| cext_line_i | input | 1 | Critical external interrupt line |
| cfg_ext_level_i | input | 1 | External flag follows its line |
| cfg_cext_level_i | input | 1 | Critical external flag follows its line |
| cfg_dec_clr_i | input | 1 | Decrementer cleared on delivery |
| msr_ee_i | input | 1 | External enable bit |
| msr_ce_i | input | 1 | Critical enable bit |
| msr_hv_i | input | 1 | Hypervisor state bit |
| msr_pr_i | input | 1 | Problem state bit |
| hdec_en_i | input | 1 | Hypervisor decrementer enable |
| ack_i | input | 1 | Delivery acknowledge from exception entry |
| grant_valid_o | output | 1 | Grant strobe, held until acknowledge |
| grant_vec_o | output | 14 | One-hot granted source |
| grant_id_o | output | 4 | Index of granted source |
| req_any_o | output | 1 | Summary request, any flag pending |

## Verification
The selector is driven with single pulses, with several simultaneous pulses spread across the priority range, and with a burst raising every event source at once and then draining it. These patterns separate a correct priority order from a reversed or shifted one, and show which flags survive the acknowledge. The enable bits are swept while requests wait, which shows that gating delays a grant without losing the flag, and that the hypervisor decrementer responds to each term of its mode condition. Level and latched modes of the external line, the decrementer option, and set-versus-clear collisions each get their own pattern, because each produces a different regrant-or-drop result after the acknowledge.

// File: rtl/ipsel_pkg.sv
package ipsel_pkg;
    localparam int NSRC = 14;
    localparam int IDW  = $clog2(NSRC);

    typedef logic [NSRC-1:0] src_vec_t;

    localparam int SRC_RST  = 0;
    localparam int SRC_MCK  = 1;
    localparam int SRC_DBG  = 2;
    localparam int SRC_HDEC = 3;
    localparam int SRC_CEXT = 4;
    localparam int SRC_WDT  = 5;
    localparam int SRC_CDB  = 6;
    localparam int SRC_FIT  = 7;
    localparam int SRC_PIT  = 8;
    localparam int SRC_DEC  = 9;
    localparam int SRC_EXT  = 10;
    localparam int SRC_DB   = 11;
    localparam int SRC_PMU  = 12;
    localparam int SRC_THM  = 13;

    // sources whose flag always drops on delivery
    localparam src_vec_t AUTO_CLR_MASK = 14'b11100111100111;
    // sources gated by the critical enable
    localparam src_vec_t CE_MASK       = 14'b00000001110100;
    // sources gated by the external enable
    localparam src_vec_t EE_MASK       = 14'b11111110000000;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } sel_state_t;
endpackage

// File: rtl/ipsel_pending.sv
module ipsel_pending
    import ipsel_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t set_i,
    input  src_vec_t clr_i,
    input  src_vec_t dlv_i,
    input  logic     ext_line_i,
    input  logic     cext_line_i,
    input  logic     cfg_ext_level_i,
    input  logic     cfg_cext_level_i,
    input  logic     cfg_dec_clr_i,
    output src_vec_t pend_o
);
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        logic flag_q;
        assign pend_o[i] = flag_q;

        if (i == SRC_EXT || i == SRC_CEXT) begin : g_line
            logic lvl_mode;
            logic line;
            assign lvl_mode = (i == SRC_EXT) ? cfg_ext_level_i : cfg_cext_level_i;
            assign line     = (i == SRC_EXT) ? ext_line_i : cext_line_i;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                   flag_q <= 1'b0;
                else if (lvl_mode)            flag_q <= line;
                else if (set_i[i] || line)    flag_q <= 1'b1;
                else if (dlv_i[i] || clr_i[i]) flag_q <= 1'b0;
            end
        end else begin : g_evt
            logic drop;
            if (i == SRC_DEC) begin : g_dec
                assign drop = clr_i[i] | (dlv_i[i] & cfg_dec_clr_i);
            end else if (AUTO_CLR_MASK[i]) begin : g_auto
                assign drop = clr_i[i] | dlv_i[i];
            end else begin : g_keep
                assign drop = clr_i[i];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        flag_q <= 1'b0;
                else if (set_i[i]) flag_q <= 1'b1;
                else if (drop)     flag_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ipsel_eligible.sv
module ipsel_eligible
    import ipsel_pkg::*;
(
    input  src_vec_t pend_i,
    input  logic     msr_ee_i,
    input  logic     msr_ce_i,
    input  logic     msr_hv_i,
    input  logic     msr_pr_i,
    input  logic     hdec_en_i,
    output src_vec_t elig_o
);
    logic hdec_ok;
    assign hdec_ok = hdec_en_i & (msr_ee_i | ~msr_hv_i | msr_pr_i);

    for (genvar i = 0; i < NSRC; i++) begin : g_gate
        if (i == SRC_HDEC) begin : g_hdec
            assign elig_o[i] = pend_i[i] & hdec_ok;
        end else if (CE_MASK[i]) begin : g_ce
            assign elig_o[i] = pend_i[i] & msr_ce_i;
        end else if (EE_MASK[i]) begin : g_ee
            assign elig_o[i] = pend_i[i] & msr_ee_i;
        end else begin : g_open
            assign elig_o[i] = pend_i[i];
        end
    end
endmodule

// File: rtl/ipsel_prio.sv
module ipsel_prio
    import ipsel_pkg::*;
(
    input  src_vec_t        elig_i,
    output src_vec_t        pick_vec_o,
    output logic [IDW-1:0]  pick_id_o,
    output logic            pick_any_o
);
    always_comb begin
        pick_vec_o = '0;
        pick_id_o  = '0;
        pick_any_o = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig_i[i] && !pick_any_o) begin
                pick_vec_o[i] = 1'b1;
                pick_id_o     = IDW'(i);
                pick_any_o    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ipsel_top.sv
module ipsel_top
    import ipsel_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [13:0]     set_i,
    input  logic [13:0]     clr_i,
    input  logic            ext_line_i,
    input  logic            cext_line_i,
    input  logic            cfg_ext_level_i,
    input  logic            cfg_cext_level_i,
    input  logic            cfg_dec_clr_i,
    input  logic            msr_ee_i,
    input  logic            msr_ce_i,
    input  logic            msr_hv_i,
    input  logic            msr_pr_i,
    input  logic            hdec_en_i,
    input  logic            ack_i,
    output logic            grant_valid_o,
    output logic [13:0]     grant_vec_o,
    output logic [3:0]      grant_id_o,
    output logic            req_any_o
);
    sel_state_t     state_q, state_d;
    src_vec_t       pend_q;
    src_vec_t       elig;
    src_vec_t       pick_vec;
    logic [IDW-1:0] pick_id;
    logic           pick_any;
    src_vec_t       grant_q;
    logic [IDW-1:0] id_q;
    src_vec_t       dlv;

    assign dlv = (state_q == ST_WAIT && ack_i) ? grant_q : '0;

    ipsel_pending u_pend (
        .clk              (clk),
        .rst_n            (rst_n),
        .set_i            (set_i),
        .clr_i            (clr_i),
        .dlv_i            (dlv),
        .ext_line_i       (ext_line_i),
        .cext_line_i      (cext_line_i),
        .cfg_ext_level_i  (cfg_ext_level_i),
        .cfg_cext_level_i (cfg_cext_level_i),
        .cfg_dec_clr_i    (cfg_dec_clr_i),
        .pend_o           (pend_q)
    );

    ipsel_eligible u_elig (
        .pend_i    (pend_q),
        .msr_ee_i  (msr_ee_i),
        .msr_ce_i  (msr_ce_i),
        .msr_hv_i  (msr_hv_i),
        .msr_pr_i  (msr_pr_i),
        .hdec_en_i (hdec_en_i),
        .elig_o    (elig)
    );

    ipsel_prio u_prio (
        .elig_i     (elig),
        .pick_vec_o (pick_vec),
        .pick_id_o  (pick_id),
        .pick_any_o (pick_any)
    );

    // next-state: pick / idle / hold / retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = pick_any ? ST_WAIT : ST_IDLE;
            ST_WAIT: state_d = ack_i ? ST_IDLE : ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered grant outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_q <= '0;
            id_q    <= '0;
        end else if (state_q == ST_IDLE && pick_any) begin
            grant_q <= pick_vec;
            id_q    <= pick_id;
        end else if (state_q == ST_WAIT && ack_i) begin
            grant_q <= '0;
        end
    end

    assign grant_valid_o = (state_q == ST_WAIT);
    assign grant_vec_o   = grant_q;
    assign grant_id_o    = id_q;
    assign req_any_o     = |pend_q;
endmodule

// File: rtl/ipsel_checker.sv
module ipsel_checker
    import ipsel_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [13:0] set_i,
    input logic [13:0] clr_i,
    input logic        msr_ee_i,
    input logic        msr_hv_i,
    input logic        msr_pr_i,
    input logic        hdec_en_i,
    input logic        ack_i,
    input logic        grant_valid_o,
    input logic [13:0] grant_vec_o,
    input logic [3:0]  grant_id_o,
    input logic        req_any_o,
    input logic [13:0] pend
);
    assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> ($countones(grant_vec_o) == 1 && grant_vec_o[grant_id_o]));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && !ack_i) |=> (grant_valid_o && $stable(grant_vec_o)));

    assert_retire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && ack_i) |=> !grant_valid_o);

    assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid_o) |-> $past(req_any_o));

    assert_hdec_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(grant_valid_o) && grant_vec_o[SRC_HDEC]) |->
            $past(hdec_en_i && (msr_ee_i || !msr_hv_i || msr_pr_i)));

    assert_hdec_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && ack_i && grant_vec_o[SRC_HDEC] && !clr_i[SRC_HDEC]) |=> pend[SRC_HDEC]);

    assert_ee_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(grant_valid_o) && |(grant_vec_o & EE_MASK)) |-> $past(msr_ee_i));

    for (genvar i = 0; i < NSRC; i++) begin : g_auto
        if (AUTO_CLR_MASK[i]) begin : g_chk
            assert_autoclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (grant_valid_o && ack_i && grant_vec_o[i] && !set_i[i]) |=> !pend[i]);
        end
    end
endmodule

bind ipsel_top ipsel_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .set_i         (set_i),
    .clr_i         (clr_i),
    .msr_ee_i      (msr_ee_i),
    .msr_hv_i      (msr_hv_i),
    .msr_pr_i      (msr_pr_i),
    .hdec_en_i     (hdec_en_i),
    .ack_i         (ack_i),
    .grant_valid_o (grant_valid_o),
    .grant_vec_o   (grant_vec_o),
    .grant_id_o    (grant_id_o),
    .req_any_o     (req_any_o),
    .pend          (pend_q)
);

// File: tb/ipsel_top_tb.sv
module ipsel_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] set_i = '0;
    logic [13:0] clr_i = '0;
    logic        ext_line_i = 1'b0;
    logic        cext_line_i = 1'b0;
    logic        cfg_ext_level_i = 1'b0;
    logic        cfg_cext_level_i = 1'b0;
    logic        cfg_dec_clr_i = 1'b1;
    logic        msr_ee_i = 1'b1;
    logic        msr_ce_i = 1'b1;
    logic        msr_hv_i = 1'b1;
    logic        msr_pr_i = 1'b0;
    logic        hdec_en_i = 1'b0;
    logic        ack_i = 1'b0;
    logic        grant_valid_o;
    logic [13:0] grant_vec_o;
    logic [3:0]  grant_id_o;
    logic        req_any_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ipsel_top u_dut (.*);

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse(logic [13:0] v);
        set_i = v;
        tick();
        set_i = '0;
    endtask

    task automatic do_ack();
        ack_i = 1'b1;
        tick();
        ack_i = 1'b0;
    endtask

    task automatic expect_grant(string req, int id);
        chk(req, "valid", int'(grant_valid_o), 1);
        chk(req, "id", int'(grant_id_o), id);
        chk(req, "vec", int'(grant_vec_o), 1 << id);
    endtask

    task automatic t_reset();
        chk("R1", "valid", int'(grant_valid_o), 0);
        chk("R1", "req_any", int'(req_any_o), 0);
    endtask

    task automatic t_single();
        pulse(14'(1) << 7);
        tick();
        expect_grant("R5", 7);
        chk("R2", "req_any", int'(req_any_o), 1);
        do_ack();
        chk("R4", "valid after ack", int'(grant_valid_o), 0);
        chk("R5", "req_any after ack", int'(req_any_o), 0);
    endtask

    task automatic t_unmaskable();
        msr_ee_i = 1'b0; msr_ce_i = 1'b0;
        pulse(14'b11);
        tick();
        expect_grant("R9", 0);
        do_ack();
        tick();
        expect_grant("R9", 1);
        do_ack();
        chk("R5", "req_any", int'(req_any_o), 0);
        msr_ee_i = 1'b1; msr_ce_i = 1'b1;
    endtask

    task automatic t_priority();
        pulse((14'(1) << 13) | (14'(1) << 9) | (14'(1) << 5) | (14'(1) << 2));
        tick();
        expect_grant("R3", 2);
        tick();
        expect_grant("R4", 2);
        do_ack();
        chk("R4", "gap after ack", int'(grant_valid_o), 0);
        chk("R4", "others pending", int'(req_any_o), 1);
        tick(); expect_grant("R3", 5); do_ack();
        tick(); expect_grant("R3", 9); do_ack();
        tick(); expect_grant("R3", 13); do_ack();
        chk("R2", "req_any drained", int'(req_any_o), 0);
    endtask

    task automatic t_walk();
        pulse(14'h3FFF & ~(14'(1) << 3));
        for (int k = 0; k < 14; k++) begin
            if (k != 3) begin
                tick();
                expect_grant("R3", k);
                do_ack();
            end
        end
        chk("R3", "walk drained", int'(req_any_o), 0);
    endtask

    task automatic t_mask();
        msr_ee_i = 1'b0; msr_ce_i = 1'b0;
        pulse((14'(1) << 10) | (14'(1) << 5));
        tick();
        chk("R9", "masked valid", int'(grant_valid_o), 0);
        chk("R2", "masked req_any", int'(req_any_o), 1);
        msr_ce_i = 1'b1;
        tick();
        expect_grant("R9", 5);
        do_ack();
        tick();
        chk("R9", "ee masked", int'(grant_valid_o), 0);
        msr_ee_i = 1'b1;
        tick();
        expect_grant("R9", 10);
        do_ack();
        chk("R6", "latched ext cleared", int'(req_any_o), 0);
    endtask

    task automatic t_dec();
        cfg_dec_clr_i = 1'b0;
        pulse(14'(1) << 9);
        tick();
        expect_grant("R7", 9);
        do_ack();
        tick();
        expect_grant("R7", 9);
        clr_i = 14'(1) << 9;
        do_ack();
        clr_i = '0;
        tick();
        chk("R10", "withdrawn valid", int'(grant_valid_o), 0);
        chk("R10", "withdrawn req_any", int'(req_any_o), 0);
        cfg_dec_clr_i = 1'b1;
    endtask

    task automatic t_hdec();
        hdec_en_i = 1'b0; msr_ee_i = 1'b1;
        pulse(14'(1) << 3);
        tick();
        chk("R8", "disabled", int'(grant_valid_o), 0);
        hdec_en_i = 1'b1; msr_ee_i = 1'b0; msr_hv_i = 1'b1; msr_pr_i = 1'b0;
        tick();
        chk("R8", "mode blocks", int'(grant_valid_o), 0);
        msr_pr_i = 1'b1;
        tick();
        expect_grant("R8", 3);
        do_ack();
        tick();
        expect_grant("R8", 3);
        msr_pr_i = 1'b0; msr_hv_i = 1'b0;
        do_ack();
        tick();
        expect_grant("R8", 3);
        clr_i = 14'(1) << 3;
        do_ack();
        clr_i = '0;
        chk("R10", "hdec withdrawn", int'(req_any_o), 0);
        msr_hv_i = 1'b1; hdec_en_i = 1'b0; msr_ee_i = 1'b1;
    endtask

    task automatic t_level();
        cfg_ext_level_i = 1'b1;
        ext_line_i = 1'b1;
        tick();
        tick();
        expect_grant("R6", 10);
        do_ack();
        tick();
        expect_grant("R6", 10);
        ext_line_i = 1'b0;
        do_ack();
        tick();
        chk("R6", "line low valid", int'(grant_valid_o), 0);
        chk("R6", "line low req_any", int'(req_any_o), 0);
        cfg_ext_level_i = 1'b0;
        ext_line_i = 1'b1;
        tick();
        ext_line_i = 1'b0;
        tick();
        expect_grant("R6", 10);
        do_ack();
        tick();
        chk("R6", "latched cleared", int'(req_any_o), 0);
        cfg_cext_level_i = 1'b1;
        cext_line_i = 1'b1;
        tick(); tick();
        expect_grant("R6", 4);
        do_ack();
        tick();
        expect_grant("R6", 4);
        cext_line_i = 1'b0;
        do_ack();
        chk("R6", "cext follows line", int'(req_any_o), 0);
        cfg_cext_level_i = 1'b0;
    endtask

    task automatic t_setwins();
        pulse(14'(1) << 7);
        tick();
        expect_grant("R10", 7);
        set_i = 14'(1) << 7;
        do_ack();
        set_i = '0;
        tick();
        expect_grant("R10", 7);
        do_ack();
        chk("R10", "cleared after second ack", int'(req_any_o), 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_single();
        t_unmaskable();
        t_priority();
        t_walk();
        t_mask();
        t_dec();
        t_hdec();
        t_level();
        t_setwins();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule